// File: doc/BRIEF.md
# Multi-channel auto-reload timer control

This block holds five down-counting timer channels behind one register port. Each channel keeps a count buffer and an active counter. Channels 0 to 3 also keep a compare buffer and an active compare value; channel 4 has neither. One shared control register gives each channel a run bit, a load bit, an output-invert bit (channels 0 to 3 only) and a repeat bit. The counters step down on single-cycle strobes from an outside tick source, one strobe input per channel. Each channel drives a PWM level and a one-clock expiry pulse.

Software writes the buffers and then uses the control register. Control bits act on edges, not levels. Raising a load bit copies the buffers into the active counter and compare. Setting a run bit starts the count, and clearing it freezes the count. When a counter reaches zero and one more tick arrives, the channel either refills from its buffer and keeps running (repeat set), or it stops and the hardware clears its run bit (repeat clear). Software reads the live counter at a per-channel observation address.

The register port is a plain single-cycle strobe with a combinational read path and no back-pressure. A write lands at the clock edge that samples `reg_wr`. `reg_rdata` always reflects `reg_addr` and the current state. The tick and expiry pins are plain strobes with no handshake.

Top module: `multi_tmr`

## Requirements
- R1: After reset, the control register, every count and compare buffer, every active counter and every active compare read 0. `expire_o` is 0 and all channels are stopped.
- R2: Mapped byte addresses:
  - Control is at 0x08.
  - The count buffer of channel n is at 0x0C+12·n.
  - The compare buffer of channel n<4 is at 0x10+12·n.
  - The observation register of channel n<4 is at 0x14+12·n; channel 4's is at 0x40.

  Buffers take the low 16 bits of a write and read back zero-extended. Any other address reads 0, and a write to it changes nothing.
- R3: Control bit layout:
  - Channel 0 uses bit 0 for run, bit 1 for load, bit 2 for invert and bit 3 for repeat.
  - Channel n in 1..3 uses base 4n+4 with the same offsets.
  - Channel 4 uses bit 20 for run, bit 21 for load and bit 22 for repeat.

  All other bits are not stored and read 0, so writing all ones reads back 0x7FFF0F.
- R4: A control write whose load bit goes 0→1 for a channel copies that channel's count buffer into its counter and its compare buffer into its active compare, effective the next cycle. Writing a load bit that is already 1 loads nothing.
- R5: While a channel's run bit is 1, each tick with the counter above zero lowers the counter by one. While the run bit is 0, ticks leave the counter unchanged.
- R6: A tick that finds a running counter at zero raises that channel's `expire_o` for exactly the following cycle. With repeat set, the counter refills from the count buffer, the active compare refills from the compare buffer, and the channel keeps running.
- R7: The same expiry with repeat clear leaves the counter at 0 and clears that channel's run bit in the control register. Further ticks have no effect.
- R8: `pwm_o[n]` is (counter > active compare) XOR invert bit. Channel 4 compares against 0 and has no invert.
- R9: A tick that arrives in the same cycle as a control-register write is dropped for every channel.
- R10: An observation register returns the live counter value as of the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 7 | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tick_i | input | 5 | Per-channel count strobe |
| expire_o | output | 5 | Per-channel one-clock expiry pulse |
| pwm_o | output | 5 | Per-channel PWM level |

## Verification
The hardest situations to reach from the ports are the overlaps. One is a tick in the same cycle as a control write. Another is a load edge hidden by a load bit that is already set. A third is a buffer write in the cycle a repeat expiry refills from that buffer. Directed steps set up each overlap on its own, with literal expected counts. A long seeded random phase then mixes random control words (with many load and run edges), writes of small buffer values so counters hit zero often, and dense random ticks. A bench reference model predicts every output and observation read in every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH    = 5;
  localparam int CTRL_W = 23;
  localparam int CTRL_ADDR = 8;

  function automatic int f_run(input int ch);
    return (ch == 0) ? 0 : 4 * ch + 4;
  endfunction

  function automatic int f_load(input int ch);
    return f_run(ch) + 1;
  endfunction

  function automatic int f_inv(input int ch);
    return f_run(ch) + 2;
  endfunction

  // last channel has no invert bit; its repeat bit sits where invert would be
  function automatic int f_rep(input int ch);
    return (ch == NCH - 1) ? 22 : f_run(ch) + 3;
  endfunction

  function automatic bit f_has_cmp(input int ch);
    return ch != NCH - 1;
  endfunction

  function automatic int f_cbuf_addr(input int ch);
    return 12 + 12 * ch;
  endfunction

  function automatic int f_mbuf_addr(input int ch);
    return 16 + 12 * ch;
  endfunction

  function automatic int f_obs_addr(input int ch);
    return (ch == NCH - 1) ? 64 : 20 + 12 * ch;
  endfunction

  function automatic logic [CTRL_W-1:0] f_ctrl_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      m[f_run(ch)]  = 1'b1;
      m[f_load(ch)] = 1'b1;
      m[f_rep(ch)]  = 1'b1;
      if (f_has_cmp(ch)) m[f_inv(ch)] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic [NCH-1:0]    hw_stop,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [NCH-1:0]    load_rise,
  output logic [NCH-1:0]    run,
  output logic [NCH-1:0]    inv,
  output logic [NCH-1:0]    rep
);
  localparam logic [CTRL_W-1:0] MASK = f_ctrl_mask();

  logic [CTRL_W-1:0] clr;

  always_comb begin
    clr = '0;
    for (int ch = 0; ch < NCH; ch++)
      if (hw_stop[ch]) clr[f_run(ch)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (wr) ctrl_q <= wdata & MASK;
    else         ctrl_q <= ctrl_q & ~clr;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_bits
    assign run[g]       = ctrl_q[f_run(g)];
    assign rep[g]       = ctrl_q[f_rep(g)];
    assign load_rise[g] = wr & wdata[f_load(g)] & ~ctrl_q[f_load(g)];
    if (f_has_cmp(g)) begin : g_inv
      assign inv[g] = ctrl_q[f_inv(g)];
    end else begin : g_noinv
      assign inv[g] = 1'b0;
    end

    assert_oneshot_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_stop[g] && !wr) |=> !run[g]);
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W   = 16,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cbuf_we,
  input  logic             mbuf_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             run,
  input  logic             rep,
  input  logic             inv,
  input  logic             load_rise,
  input  logic             ctrl_wr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cbuf_q,
  output logic [CNT_W-1:0] mbuf_q,
  output logic             expire,
  output logic             hw_stop,
  output logic             pwm
);
  logic [CNT_W-1:0] cmp_q;
  logic             tick_ok;
  logic             at_zero;

  assign tick_ok = tick & run & ~ctrl_wr;
  assign at_zero = (cnt_q == '0);
  assign hw_stop = tick_ok & at_zero & ~rep & ~load_rise;
  assign pwm     = (cnt_q > cmp_q) ^ inv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cbuf_q <= '0;
      mbuf_q <= '0;
    end else begin
      if (cbuf_we)            cbuf_q <= wdata;
      if (mbuf_we && HAS_CMP) mbuf_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load_rise) begin
        cnt_q <= cbuf_q;
        cmp_q <= mbuf_q;
      end else if (tick_ok) begin
        if (at_zero) begin
          expire <= 1'b1;
          if (rep) begin
            cnt_q <= cbuf_q;
            cmp_q <= mbuf_q;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assert_load_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> cnt_q == $past(cbuf_q));
  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ok && !at_zero && !load_rise) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_rise) |=> $stable(cnt_q));
  assert_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ok && at_zero && rep && !load_rise) |=> (cnt_q == $past(cbuf_q)) && expire);
  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(tick));
  assert_tick_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !load_rise) |=> $stable(cnt_q));
endmodule

// File: rtl/multi_tmr.sv
module multi_tmr
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NCH-1:0]    tick_i,
  output logic [NCH-1:0]    expire_o,
  output logic [NCH-1:0]    pwm_o
);
  logic              ctrl_wr;
  logic [CTRL_W-1:0] ctrl_q;
  logic [NCH-1:0]    load_rise, run, inv, rep, hw_stop;
  logic [CNT_W-1:0]  cnt_a  [NCH];
  logic [CNT_W-1:0]  cbuf_a [NCH];
  logic [CNT_W-1:0]  mbuf_a [NCH];
  logic              unused_wdata_hi;

  assign ctrl_wr         = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CTRL_W];

  tmr_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (ctrl_wr),
    .wdata     (reg_wdata[CTRL_W-1:0]),
    .hw_stop   (hw_stop),
    .ctrl_q    (ctrl_q),
    .load_rise (load_rise),
    .run       (run),
    .inv       (inv),
    .rep       (rep)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic cbuf_we, mbuf_we;
    assign cbuf_we = reg_wr && (reg_addr == ADDR_W'(f_cbuf_addr(g)));
    assign mbuf_we = f_has_cmp(g) && reg_wr && (reg_addr == ADDR_W'(f_mbuf_addr(g)));

    tmr_chan #(.CNT_W(CNT_W), .HAS_CMP(f_has_cmp(g))) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cbuf_we   (cbuf_we),
      .mbuf_we   (mbuf_we),
      .wdata     (reg_wdata[CNT_W-1:0]),
      .run       (run[g]),
      .rep       (rep[g]),
      .inv       (inv[g]),
      .load_rise (load_rise[g]),
      .ctrl_wr   (ctrl_wr),
      .tick      (tick_i[g]),
      .cnt_q     (cnt_a[g]),
      .cbuf_q    (cbuf_a[g]),
      .mbuf_q    (mbuf_a[g]),
      .expire    (expire_o[g]),
      .hw_stop   (hw_stop[g]),
      .pwm       (pwm_o[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CTRL_ADDR)) reg_rdata = DATA_W'(ctrl_q);
    for (int ch = 0; ch < NCH; ch++) begin
      if (reg_addr == ADDR_W'(f_cbuf_addr(ch))) reg_rdata = DATA_W'(cbuf_a[ch]);
      if (f_has_cmp(ch) && reg_addr == ADDR_W'(f_mbuf_addr(ch)))
        reg_rdata = DATA_W'(mbuf_a[ch]);
      if (reg_addr == ADDR_W'(f_obs_addr(ch))) reg_rdata = DATA_W'(cnt_a[ch]);
    end
  end

  assert_expire_cleared_in_reset_R1: assert property (@(posedge clk)
    !rst_n |=> expire_o == '0);
endmodule

// File: tb/tb_multi_tmr.sv
module tb_multi_tmr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4:0]  tick_i = '0;
  logic [4:0]  expire_o, pwm_o;

  always #5 clk = ~clk;

  multi_tmr dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_i(tick_i),
    .expire_o(expire_o), .pwm_o(pwm_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int m_ctrl;
  int m_cbuf[5], m_mbuf[5], m_cnt[5], m_cmp[5];
  bit [4:0] m_exp;

  function automatic int b_run(int ch); return (ch == 0) ? 0 : 4 * ch + 4; endfunction
  function automatic int b_load(int ch); return b_run(ch) + 1; endfunction
  function automatic int b_inv(int ch); return b_run(ch) + 2; endfunction
  function automatic int b_rep(int ch); return (ch == 4) ? 22 : b_run(ch) + 3; endfunction

  function automatic int mread(int a);
    if (a == 8) return m_ctrl;
    for (int ch = 0; ch < 5; ch++) begin
      if (a == 12 + 12 * ch) return m_cbuf[ch];
      if (ch < 4 && a == 16 + 12 * ch) return m_mbuf[ch];
      if (ch < 4 && a == 20 + 12 * ch) return m_cnt[ch];
    end
    if (a == 64) return m_cnt[4];
    return 0;
  endfunction

  function automatic int mpwm();
    int r = 0;
    for (int ch = 0; ch < 5; ch++) begin
      bit iv = (ch < 4) ? m_ctrl[b_inv(ch)] : 1'b0;
      if ((m_cnt[ch] > m_cmp[ch]) ^ iv) r |= (1 << ch);
    end
    return r;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic step(bit wr, int a, int d, bit [4:0] tk);
    int old, nctrl;
    bit wc;
    reg_wr = wr; reg_addr = a[6:0]; reg_wdata = d; tick_i = tk;
    old = m_ctrl;
    wc = wr && a == 8;
    nctrl = wc ? (d & 32'h7FFF0F) : old;
    m_exp = '0;
    for (int ch = 0; ch < 5; ch++) begin
      bit up = wc && d[b_load(ch)] && !old[b_load(ch)];
      bit ok = tk[ch] && old[b_run(ch)] && !wc;
      if (up) begin
        m_cnt[ch] = m_cbuf[ch]; m_cmp[ch] = m_mbuf[ch];
      end else if (ok) begin
        if (m_cnt[ch] == 0) begin
          m_exp[ch] = 1'b1;
          if (old[b_rep(ch)]) begin
            m_cnt[ch] = m_cbuf[ch]; m_cmp[ch] = m_mbuf[ch];
          end else nctrl &= ~(1 << b_run(ch));
        end else m_cnt[ch] = m_cnt[ch] - 1;
      end
    end
    if (wr)
      for (int ch = 0; ch < 5; ch++) begin
        if (a == 12 + 12 * ch) m_cbuf[ch] = d & 32'hFFFF;
        if (ch < 4 && a == 16 + 12 * ch) m_mbuf[ch] = d & 32'hFFFF;
      end
    m_ctrl = nctrl;
    @(posedge clk); #2;
    reg_wr = 1'b0; tick_i = '0;
    chk("R6", expire_o, m_exp);
    chk("R8", pwm_o, mpwm());
    chk("R10", reg_rdata, mread(a));
  endtask

  task automatic wr(int a, int d); step(1'b1, a, d, 5'b0); endtask
  task automatic rd(int a, int e, string tag);
    step(1'b0, a, 0, 5'b0);
    chk(tag, reg_rdata, e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL R5 watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_ctrl = 0;
    for (int ch = 0; ch < 5; ch++) begin
      m_cbuf[ch] = 0; m_mbuf[ch] = 0; m_cnt[ch] = 0; m_cmp[ch] = 0;
    end
    m_exp = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    rd(8, 0, "R1");
    rd(12, 0, "R1");
    rd(20, 0, "R1");
    chk("R1", expire_o, 0);

    // R4 load edge, then load bit held high loads nothing
    wr(12, 3); wr(16, 1); wr(8, 32'h2);
    rd(20, 3, "R4");
    chk("R8", pwm_o[0], 1);
    wr(12, 5); wr(8, 32'h2);
    rd(20, 3, "R4");

    // R5 count down with repeat
    wr(8, 32'h9);
    step(1'b0, 20, 0, 5'b00001); chk("R5", reg_rdata, 2);
    step(1'b0, 20, 0, 5'b00001);
    step(1'b0, 20, 0, 5'b00001); chk("R5", reg_rdata, 0);
    chk("R8", pwm_o[0], 0);
    step(1'b0, 20, 0, 5'b00001);
    chk("R6", expire_o[0], 1);
    chk("R6", reg_rdata, 5);
    rd(20, 5, "R6");
    chk("R6", expire_o[0], 0);
    // stop holds
    wr(8, 32'h8);
    step(1'b0, 20, 0, 5'b00001); chk("R5", reg_rdata, 5);

    // R7 one-shot on channel 1
    wr(24, 1); wr(8, 32'h8 | (1 << 9));
    wr(8, 32'h8 | (1 << 8));
    step(1'b0, 32, 0, 5'b00010); chk("R7", reg_rdata, 0);
    step(1'b0, 32, 0, 5'b00010); chk("R7", expire_o[1], 1);
    rd(8, 32'h8, "R7");
    step(1'b0, 32, 0, 5'b00010);
    chk("R7", expire_o[1], 0); chk("R7", reg_rdata, 0);

    // R9 tick with control write is dropped
    wr(12, 2); wr(8, 32'h8 | 32'h2);
    step(1'b1, 8, 32'h9, 5'b00001);
    rd(20, 2, "R9");
    step(1'b0, 20, 0, 5'b00001); chk("R9", reg_rdata, 1);

    // R3 layout
    wr(8, 32'hFFFF_FFFF);
    rd(8, 32'h7FFF0F, "R3");
    wr(8, 0);

    // R8 invert on channel 1
    wr(24, 4); wr(28, 2); wr(8, 1 << 9);
    chk("R8", pwm_o[1], 1);
    wr(8, (1 << 9) | (1 << 10));
    chk("R8", pwm_o[1], 0);

    // R2 map edges
    wr(68, 32'h55); rd(68, 0, "R2");
    rd(4, 0, "R2");
    rd(28, 2, "R2");
    wr(60, 32'h1_0007); rd(60, 7, "R2");
    wr(8, 1 << 21); rd(64, 7, "R10");

    // random phase
    for (int i = 0; i < 5000; i++) begin
      int sel = $urandom_range(0, 99);
      int ch = $urandom_range(0, 4);
      bit [4:0] tk = 5'($urandom);
      int ra;
      case ($urandom_range(0, 2))
        0: ra = 8;
        1: ra = (ch == 4) ? 64 : 20 + 12 * ch;
        default: ra = $urandom_range(0, 72);
      endcase
      if (sel < 8)       step(1'b1, 8, $urandom, tk);
      else if (sel < 20) step(1'b1, 12 + 12 * ch, $urandom_range(0, 6), tk);
      else if (sel < 28) step(1'b1, 16 + 12 * ch, $urandom_range(0, 6), tk);
      else if (sel < 30) step(1'b1, $urandom_range(0, 72), $urandom, tk);
      else               step(1'b0, ra, 0, tk);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule